// File: doc/BRIEF.md
# UART Receive/Transmit FIFO Pair with Interrupt Thresholds

This block holds the character buffers that sit between a UART's serial shifters and its host register interface. It contains one 64-entry receive queue and one 64-entry transmit queue. Each receive entry keeps the 8-bit character together with three error-status bits. The serial side pushes received characters and pops characters to send. The host side pops received characters and pushes characters to send. Both read ports are show-ahead: the head entry is always presented on the data outputs.

Each direction produces one interrupt request from its own threshold. The receive request is raised by occupancy and the transmit request by free space. A threshold is picked in one of three ways. With the FIFOs disabled it is one character. Otherwise a nonzero 4-bit programmable field sets it in steps of four. With that field at zero, a 2-bit selection code sets it from a fixed table. The two directions are configured independently.

Top module: `uart_fifo_pair`

## Requirements
- R1: After a reset both counts are 0, the overrun flag is 0, the receive request is 0 and the transmit request is 1.
- R2: Each queue returns entries in the order they were pushed and holds at most 64. The head entry is shown on the read data outputs, and the count reports the number of entries held.
- R3: Each receive entry keeps its 3 error bits with its character, and they appear on `host_rx_err` when that entry is at the head.
- R4: A push to a full queue is dropped and leaves the contents and count unchanged. A dropped receive push sets `rx_overrun`, which stays set until the receive clear.
- R5: A pop from an empty queue is ignored. A later push is then the next entry read.
- R6: While `fifo_en` is 0, both thresholds are 1, whatever the code and field inputs hold.
- R7: While `fifo_en` is 1 and the programmable field is 0, the threshold comes from the code. Receive codes 0,1,2,3 give 8,16,56,60. Transmit codes 0,1,2,3 give 8,16,32,56.
- R8: While `fifo_en` is 1 and the programmable field is nonzero, the threshold is the field value times 4, whatever the code says.
- R9: `rx_irq` is 1 exactly when the receive count is at or above the receive threshold. `tx_irq` is 1 exactly when 64 minus the transmit count is at or above the transmit threshold.
- R10: `rx_clr` empties the receive queue and clears `rx_overrun`. `tx_clr` empties the transmit queue. Neither clear touches the other queue, and a clear takes priority over a push or pop in the same cycle.
- R11: A push and a pop in the same cycle on a queue that is neither empty nor full both take effect, and the count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_en | input | 1 | FIFO mode; 0 forces both thresholds to 1 |
| rx_clr | input | 1 | Empty the receive queue and clear overrun |
| tx_clr | input | 1 | Empty the transmit queue |
| rx_sel | input | 2 | Receive threshold code |
| tx_sel | input | 2 | Transmit threshold code |
| rx_prog | input | 4 | Receive programmable threshold, units of 4 |
| tx_prog | input | 4 | Transmit programmable threshold, units of 4 |
| ser_rx_push | input | 1 | Serial side writes a received character |
| ser_rx_data | input | 8 | Received character |
| ser_rx_err | input | 3 | Error status of the received character |
| host_rx_pop | input | 1 | Host removes the head receive entry |
| host_rx_data | output | 8 | Head receive character |
| host_rx_err | output | 3 | Head receive error status |
| host_tx_push | input | 1 | Host writes a character to send |
| host_tx_data | input | 8 | Character to send |
| ser_tx_pop | input | 1 | Serial side removes the head transmit entry |
| ser_tx_data | output | 8 | Head transmit character |
| rx_count | output | 7 | Receive entries held |
| tx_count | output | 7 | Transmit entries held |
| rx_overrun | output | 1 | Sticky flag for a dropped receive push |
| rx_irq | output | 1 | Receive threshold reached |
| tx_irq | output | 1 | Transmit free-space threshold reached |

## Verification
The bench fills the receive queue to 64 and pushes once more. A design that wrapped its write pointer would overwrite the head and fail to raise overrun. It also checks every threshold one entry below and at its level, so an off-by-one compare, or a code table read for the wrong direction, shows up as a request one entry early or late. A nonzero programmable field is paired with a code that disagrees, which exposes a wrong priority between the two sources. A pop from an empty queue, a simultaneous push and pop, and a clear of one queue while the other holds data catch pointer slips and clears that reach across queues.

// File: rtl/uart_fifo_pkg.sv
// Shared definitions for the UART FIFO pair.
// Assumes: characters are 8 bits and each receive entry carries 3 error bits.
package uart_fifo_pkg;
    localparam int unsigned CHAR_W = 8;
    localparam int unsigned ERR_W  = 3;

    // One receive entry: error status packed above the character.
    typedef struct packed {
        logic [ERR_W-1:0]  err;
        logic [CHAR_W-1:0] data;
    } rx_entry_t;

    localparam int unsigned RX_ENTRY_W = $bits(rx_entry_t);
endpackage

// File: rtl/fifo_core.sv
// Generic synchronous FIFO with show-ahead read data.
// Assumes: a push to a full queue and a pop from an empty queue are dropped.
// clr takes priority over push and pop. DEPTH need not be a power of two.
module fifo_core #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 64,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic [CW-1:0]    count,
    output logic             full,
    output logic             drop
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic             push_ok, pop_ok;

    // Qualify requests against the state held before this edge.
    always_comb begin
        full    = (count == CW'(DEPTH));
        push_ok = push && !full && !clr;
        pop_ok  = pop && (count != '0) && !clr;
        drop    = push && full && !clr;
        rdata   = mem[rd_ptr];
    end

    // Storage write; the array carries no reset.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= wdata;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok)
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            if (push_ok && !pop_ok)
                count <= count + 1'b1;
            else if (pop_ok && !push_ok)
                count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/trig_level.sv
// Resolves the interrupt threshold of one direction.
// Assumes: disabled FIFO mode forces a threshold of 1. A nonzero programmable
// field wins over the selection code. IS_RX picks the code table.
module trig_level #(
    parameter int unsigned DEPTH  = 64,
    parameter bit          IS_RX  = 1'b1,
    parameter int unsigned PROG_W = 4,
    parameter int unsigned UNIT   = 4,
    localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic              en,
    input  logic [1:0]        sel,
    input  logic [PROG_W-1:0] prog,
    output logic [CW-1:0]     level
);
    logic [CW-1:0] table_lvl;

    // Fixed code table, chosen per direction.
    generate
        if (IS_RX) begin : g_rx_tab
            always_comb begin
                case (sel)
                    2'd0:    table_lvl = CW'(8);
                    2'd1:    table_lvl = CW'(16);
                    2'd2:    table_lvl = CW'(56);
                    default: table_lvl = CW'(60);
                endcase
            end
        end else begin : g_tx_tab
            always_comb begin
                case (sel)
                    2'd0:    table_lvl = CW'(8);
                    2'd1:    table_lvl = CW'(16);
                    2'd2:    table_lvl = CW'(32);
                    default: table_lvl = CW'(56);
                endcase
            end
        end
    endgenerate

    // Priority: disabled mode, then programmable field, then code.
    always_comb begin
        if (!en)
            level = CW'(1);
        else if (prog != '0)
            level = CW'(prog) * CW'(UNIT);
        else
            level = table_lvl;
    end
endmodule

// File: rtl/uart_fifo_pair.sv
// UART receive and transmit FIFO pair with threshold interrupts.
// Assumes: the serial side pushes RX and pops TX; the host pops RX and pushes TX.
// Requests are decoded from the registered counts, with no extra latency.
module uart_fifo_pair
    import uart_fifo_pkg::*;
#(
    parameter int unsigned DEPTH  = 64,
    parameter int unsigned PROG_W = 4,
    localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_en,
    input  logic              rx_clr,
    input  logic              tx_clr,
    input  logic [1:0]        rx_sel,
    input  logic [1:0]        tx_sel,
    input  logic [PROG_W-1:0] rx_prog,
    input  logic [PROG_W-1:0] tx_prog,
    input  logic              ser_rx_push,
    input  logic [CHAR_W-1:0] ser_rx_data,
    input  logic [ERR_W-1:0]  ser_rx_err,
    input  logic              host_rx_pop,
    output logic [CHAR_W-1:0] host_rx_data,
    output logic [ERR_W-1:0]  host_rx_err,
    input  logic              host_tx_push,
    input  logic [CHAR_W-1:0] host_tx_data,
    input  logic              ser_tx_pop,
    output logic [CHAR_W-1:0] ser_tx_data,
    output logic [CW-1:0]     rx_count,
    output logic [CW-1:0]     tx_count,
    output logic              rx_overrun,
    output logic              rx_irq,
    output logic              tx_irq
);
    rx_entry_t     rx_wr, rx_rd;
    logic          rx_full, rx_drop, tx_full, tx_drop;
    logic [CW-1:0] rx_level, tx_level, tx_space;

    // Pack the receive entry and unpack the head entry.
    always_comb begin
        rx_wr.data   = ser_rx_data;
        rx_wr.err    = ser_rx_err;
        host_rx_data = rx_rd.data;
        host_rx_err  = rx_rd.err;
    end

    fifo_core #(.WIDTH(RX_ENTRY_W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr),
        .push(ser_rx_push), .wdata(rx_wr), .pop(host_rx_pop),
        .rdata(rx_rd), .count(rx_count), .full(rx_full), .drop(rx_drop)
    );

    fifo_core #(.WIDTH(CHAR_W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr),
        .push(host_tx_push), .wdata(host_tx_data), .pop(ser_tx_pop),
        .rdata(ser_tx_data), .count(tx_count), .full(tx_full), .drop(tx_drop)
    );

    trig_level #(.DEPTH(DEPTH), .IS_RX(1'b1), .PROG_W(PROG_W)) u_rxlvl (
        .en(fifo_en), .sel(rx_sel), .prog(rx_prog), .level(rx_level)
    );

    trig_level #(.DEPTH(DEPTH), .IS_RX(1'b0), .PROG_W(PROG_W)) u_txlvl (
        .en(fifo_en), .sel(tx_sel), .prog(tx_prog), .level(tx_level)
    );

    // Sticky overrun: set by a dropped receive push, cleared by the receive clear.
    always_ff @(posedge clk) begin
        if (!rst_n || rx_clr) rx_overrun <= 1'b0;
        else if (rx_drop)     rx_overrun <= 1'b1;
    end

    // Threshold compares; the transmit side looks at free space.
    always_comb begin
        tx_space = CW'(DEPTH) - tx_count;
        rx_irq   = (rx_count >= rx_level);
        tx_irq   = (tx_space >= tx_level);
    end

    // The transmit-side full and drop indications have no consumer here.
    logic unused_ok;
    always_comb unused_ok = ^{rx_full, tx_full, tx_drop};
endmodule

// File: rtl/uart_fifo_pair_chk.sv
// Property checker for uart_fifo_pair, attached by bind.
// Assumes: the same DEPTH as the bound instance.
module uart_fifo_pair_chk #(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_clr,
    input logic          tx_clr,
    input logic          ser_rx_push,
    input logic          host_rx_pop,
    input logic          host_tx_push,
    input logic          ser_tx_pop,
    input logic [CW-1:0] rx_count,
    input logic [CW-1:0] tx_count,
    input logic          rx_overrun,
    input logic          rx_irq,
    input logic          tx_irq
);
    // R2: occupancy never exceeds the depth.
    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count <= CW'(DEPTH)) && (tx_count <= CW'(DEPTH)));

    // R4: a receive push into a full queue raises overrun and keeps the count.
    a_r4_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_rx_push && !host_rx_pop && !rx_clr && rx_count == CW'(DEPTH))
        |=> (rx_overrun && rx_count == CW'(DEPTH)));

    // R10: each clear empties its own queue on the next cycle.
    a_r10_rx_clear: assert property (@(posedge clk) disable iff (!rst_n)
        rx_clr |=> (rx_count == '0 && !rx_overrun));
    a_r10_tx_clear: assert property (@(posedge clk) disable iff (!rst_n)
        tx_clr |=> (tx_count == '0));

    // R11: a push and a pop on a partly filled receive queue keep the count.
    a_r11_rx_balance: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_rx_push && host_rx_pop && !rx_clr && rx_count != '0 && rx_count != CW'(DEPTH))
        |=> $stable(rx_count));

    // R5: a pop from an empty queue leaves it empty.
    a_r5_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rx_pop && !ser_rx_push && rx_count == '0) |=> (rx_count == '0));

    // R9: thresholds are at least 1, so an empty RX or full TX cannot request.
    a_r9_irq_sane: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == '0 -> !rx_irq) && (tx_count == CW'(DEPTH) -> !tx_irq));
endmodule

bind uart_fifo_pair uart_fifo_pair_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_clr(rx_clr), .tx_clr(tx_clr),
    .ser_rx_push(ser_rx_push), .host_rx_pop(host_rx_pop),
    .host_tx_push(host_tx_push), .ser_tx_pop(ser_tx_pop),
    .rx_count(rx_count), .tx_count(tx_count), .rx_overrun(rx_overrun),
    .rx_irq(rx_irq), .tx_irq(tx_irq)
);

// File: tb/sim_uart_fifo_pair.sv
module sim_uart_fifo_pair;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 64;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b0, rx_clr = 1'b0, tx_clr = 1'b0;
    logic [1:0] rx_sel = 2'd0, tx_sel = 2'd0;
    logic [3:0] rx_prog = 4'd0, tx_prog = 4'd0;
    logic       ser_rx_push = 1'b0, host_rx_pop = 1'b0, host_tx_push = 1'b0, ser_tx_pop = 1'b0;
    logic [7:0] ser_rx_data = 8'd0, host_tx_data = 8'd0;
    logic [2:0] ser_rx_err = 3'd0;
    logic [7:0] host_rx_data, ser_tx_data;
    logic [2:0] host_rx_err;
    logic [6:0] rx_count, tx_count;
    logic       rx_overrun, rx_irq, tx_irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_fifo_pair u0 (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rx_clr(rx_clr), .tx_clr(tx_clr),
        .rx_sel(rx_sel), .tx_sel(tx_sel), .rx_prog(rx_prog), .tx_prog(tx_prog),
        .ser_rx_push(ser_rx_push), .ser_rx_data(ser_rx_data), .ser_rx_err(ser_rx_err),
        .host_rx_pop(host_rx_pop), .host_rx_data(host_rx_data), .host_rx_err(host_rx_err),
        .host_tx_push(host_tx_push), .host_tx_data(host_tx_data),
        .ser_tx_pop(ser_tx_pop), .ser_tx_data(ser_tx_data),
        .rx_count(rx_count), .tx_count(tx_count), .rx_overrun(rx_overrun),
        .rx_irq(rx_irq), .tx_irq(tx_irq)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Each helper drives at a falling edge; the result is visible at the next one.
    task automatic rx_push(input logic [7:0] d, input logic [2:0] e);
        @(negedge clk); ser_rx_push = 1'b1; ser_rx_data = d; ser_rx_err = e;
        @(negedge clk); ser_rx_push = 1'b0;
    endtask
    task automatic rx_pop();
        @(negedge clk); host_rx_pop = 1'b1;
        @(negedge clk); host_rx_pop = 1'b0;
    endtask
    task automatic tx_push(input logic [7:0] d);
        @(negedge clk); host_tx_push = 1'b1; host_tx_data = d;
        @(negedge clk); host_tx_push = 1'b0;
    endtask
    task automatic tx_pop();
        @(negedge clk); ser_tx_pop = 1'b1;
        @(negedge clk); ser_tx_pop = 1'b0;
    endtask
    task automatic clear_both();
        @(negedge clk); rx_clr = 1'b1; tx_clr = 1'b1;
        @(negedge clk); rx_clr = 1'b0; tx_clr = 1'b0;
    endtask
    task automatic rx_fill(input int n);
        for (int i = 0; i < n; i++) rx_push(8'(i), 3'(i));
    endtask
    task automatic tx_fill(input int n);
        for (int i = 0; i < n; i++) tx_push(8'(i));
    endtask

    // RX request just below and at level lvl.
    task automatic rx_edge(input string req, input int lvl);
        clear_both();
        rx_fill(lvl - 1);
        check(req, "rx_irq below level", int'(rx_irq), 0);
        rx_push(8'hAA, 3'd0);
        check(req, "rx_irq at level", int'(rx_irq), 1);
    endtask

    // TX request with free space one below and at level lvl.
    task automatic tx_edge(input string req, input int lvl);
        clear_both();
        tx_fill(DEPTH - lvl + 1);
        check(req, "tx_irq below level", int'(tx_irq), 0);
        tx_pop();
        check(req, "tx_irq at level", int'(tx_irq), 1);
    endtask

    task automatic t_reset();
        check("R1", "rx_count", int'(rx_count), 0);
        check("R1", "tx_count", int'(tx_count), 0);
        check("R1", "rx_overrun", int'(rx_overrun), 0);
        check("R1", "rx_irq", int'(rx_irq), 0);
        check("R1", "tx_irq", int'(tx_irq), 1);
    endtask

    task automatic t_order();
        clear_both();
        rx_push(8'h11, 3'd5); rx_push(8'h22, 3'd2); rx_push(8'h33, 3'd7);
        check("R2", "rx_count", int'(rx_count), 3);
        check("R2", "head data", int'(host_rx_data), 'h11);
        check("R3", "head err", int'(host_rx_err), 5);
        rx_pop();
        check("R2", "second data", int'(host_rx_data), 'h22);
        check("R3", "second err", int'(host_rx_err), 2);
        rx_pop();
        check("R3", "third err", int'(host_rx_err), 7);
        tx_push(8'h5A); tx_push(8'hA5);
        check("R2", "tx head", int'(ser_tx_data), 'h5A);
        tx_pop();
        check("R2", "tx second", int'(ser_tx_data), 'hA5);
    endtask

    task automatic t_full();
        int bad;
        clear_both();
        rx_fill(DEPTH);
        check("R2", "rx full count", int'(rx_count), DEPTH);
        check("R4", "no overrun yet", int'(rx_overrun), 0);
        rx_push(8'hEE, 3'd1);
        check("R4", "count after drop", int'(rx_count), DEPTH);
        check("R4", "overrun set", int'(rx_overrun), 1);
        check("R4", "head kept", int'(host_rx_data), 0);
        bad = 0;
        for (int i = 0; i < DEPTH; i++) begin
            if (host_rx_data != 8'(i) || host_rx_err != 3'(i)) bad++;
            rx_pop();
        end
        check("R2", "order over 64 entries (mismatches)", bad, 0);
        check("R4", "overrun sticky after draining", int'(rx_overrun), 1);
        tx_fill(DEPTH + 1);
        check("R4", "tx count after drop", int'(tx_count), DEPTH);
        check("R4", "tx head kept", int'(ser_tx_data), 0);
    endtask

    task automatic t_clear();
        clear_both();
        rx_push(8'h01, 3'd0); rx_push(8'h02, 3'd0);
        tx_push(8'h03); tx_push(8'h04); tx_push(8'h05);
        @(negedge clk); rx_clr = 1'b1; ser_rx_push = 1'b1;
        @(negedge clk); rx_clr = 1'b0; ser_rx_push = 1'b0;
        check("R10", "rx emptied, push ignored", int'(rx_count), 0);
        check("R10", "tx untouched", int'(tx_count), 3);
        check("R10", "tx head untouched", int'(ser_tx_data), 'h03);
        @(negedge clk); tx_clr = 1'b1;
        @(negedge clk); tx_clr = 1'b0;
        check("R10", "tx emptied", int'(tx_count), 0);
        // overrun cleared by the receive clear
        rx_fill(DEPTH); rx_push(8'h00, 3'd0);
        @(negedge clk); rx_clr = 1'b1;
        @(negedge clk); rx_clr = 1'b0;
        check("R10", "overrun cleared", int'(rx_overrun), 0);
    endtask

    task automatic t_empty_pop();
        clear_both();
        rx_pop(); tx_pop();
        check("R5", "rx count after empty pop", int'(rx_count), 0);
        check("R5", "tx count after empty pop", int'(tx_count), 0);
        rx_push(8'h77, 3'd3); tx_push(8'h66);
        check("R5", "rx next entry", int'(host_rx_data), 'h77);
        check("R5", "tx next entry", int'(ser_tx_data), 'h66);
    endtask

    task automatic t_disabled();
        fifo_en = 1'b0; rx_sel = 2'd3; tx_sel = 2'd3; rx_prog = 4'd9; tx_prog = 4'd9;
        rx_edge("R6", 1);
        tx_edge("R6", 1);
    endtask

    task automatic t_codes();
        int rx_tab [4] = '{8, 16, 56, 60};
        int tx_tab [4] = '{8, 16, 32, 56};
        fifo_en = 1'b1; rx_prog = 4'd0; tx_prog = 4'd0;
        for (int c = 0; c < 4; c++) begin
            rx_sel = 2'(c); tx_sel = 2'(c);
            rx_edge("R7", rx_tab[c]);
            tx_edge("R7", tx_tab[c]);
        end
        // R9: request drops again when occupancy falls under the level
        rx_sel = 2'd0;
        rx_edge("R9", 8);
        rx_pop();
        check("R9", "rx_irq falls below level", int'(rx_irq), 0);
    endtask

    task automatic t_prog();
        fifo_en = 1'b1; rx_sel = 2'd3; tx_sel = 2'd3;
        rx_prog = 4'd3; tx_prog = 4'd5;
        rx_edge("R8", 12);
        tx_edge("R8", 20);
        rx_prog = 4'd15; tx_prog = 4'd1;
        rx_edge("R8", 60);
        tx_edge("R8", 4);
        rx_prog = 4'd0; tx_prog = 4'd0;
    endtask

    task automatic t_simul();
        clear_both();
        rx_push(8'h10, 3'd1); rx_push(8'h20, 3'd2);
        @(negedge clk); ser_rx_push = 1'b1; ser_rx_data = 8'h30; ser_rx_err = 3'd3; host_rx_pop = 1'b1;
        @(negedge clk); ser_rx_push = 1'b0; host_rx_pop = 1'b0;
        check("R11", "rx count unchanged", int'(rx_count), 2);
        check("R11", "rx head advanced", int'(host_rx_data), 'h20);
        rx_pop();
        check("R11", "pushed entry kept", int'(host_rx_data), 'h30);
        tx_push(8'h40);
        @(negedge clk); host_tx_push = 1'b1; host_tx_data = 8'h50; ser_tx_pop = 1'b1;
        @(negedge clk); host_tx_push = 1'b0; ser_tx_pop = 1'b0;
        check("R11", "tx count unchanged", int'(tx_count), 1);
        check("R11", "tx head is new entry", int'(ser_tx_data), 'h50);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_order();
        t_full();
        t_clear();
        t_empty_pop();
        t_disabled();
        t_codes();
        t_prog();
        t_simul();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule